// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit turns an addressing-mode code, an instruction operand and two 8-bit index registers into the 16-bit address of a memory operand for an 8-bit processor core. The direct modes (first-page, first-page indexed, full-width indexed) need only arithmetic, and their result is ready one cycle after the request. The two indirect modes first read a two-byte pointer from the first 256 bytes of memory, low byte first, through a synchronous read port that returns data one cycle after the read. The unit then applies the index and publishes the address.

A request is taken when `req` is high and the unit is not busy. Each result is marked by a one-cycle `done` pulse. The address, the page-cross flag and the error flag stay unchanged until the next pulse. Opcode decoding, the arithmetic unit and result write-back are handled by other blocks.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `done`, `busy`, `mem_rd`, `ea`, `err` and `page_cross` are all zero.
- R2: Mode 0 (first page) gives `ea` = {8'h00, operand[7:0]}, with `done` high in the cycle after the accepting edge.
- R3: Mode 1 adds X and mode 2 adds Y to operand[7:0]. The carry is dropped, so the upper byte of `ea` is always 8'h00 (for example, 8'h01 + 8'hFF gives 16'h0000).
- R4: Mode 3 adds X and mode 4 adds Y to the full 16-bit operand, modulo 2^16. `page_cross` is 1 exactly when the upper byte of the sum differs from the upper byte of the operand.
- R5: Mode 5 forms p = (operand[7:0] + X) mod 256, reads the pointer low byte at {8'h00,p} and the high byte at {8'h00,(p+1) mod 256}, and sets `ea` = {high, low} with `page_cross` = 0.
- R6: Mode 6 reads the pointer at {8'h00,operand[7:0]} and at the next byte address, wrapping within the first page. It sets `ea` = pointer + Y with a full 16-bit carry, and `page_cross` = 1 when the upper byte of `ea` differs from the pointer's upper byte.
- R7: An indirect request drives `mem_rd` high for exactly two cycles: the first and second cycles after the accepting edge, low-byte address first. `done` follows three cycles after the accepting edge. Direct modes never drive `mem_rd`.
- R8: `req` is ignored while `busy` is high. A request is accepted again in the cycle where `done` is high.
- R9: Mode 7 is unsupported. It gives `err` = 1, `ea` = 16'h0000 and `page_cross` = 0, with `done` timed as in R2.
- R10: `done` is high for one cycle per accepted request, never while `busy` is high. `ea`, `err` and `page_cross` change only at the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Start a computation |
| mode | input | 3 | Addressing-mode code (see R2 to R9) |
| operand | input | 16 | Operand from the instruction; only the low byte is used in first-page modes |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_rd | output | 1 | Pointer read strobe |
| mem_addr | output | 16 | Pointer read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Indirect computation in progress |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Index addition changed the upper byte |
| err | output | 1 | Unsupported mode |

## Verification
Direct and unsupported requests are due one edge after acceptance. Indirect requests have their two pointer reads in the first and second cycles after acceptance, and their result three edges after that. The bench runs a behavioural reference model on the rising edge: it counts down the cycles left for a request and computes the expected address from its own copy of the pointer memory. It then compares every output on the falling edge of every cycle, so a result that comes early or late is caught in the cycle it differs. Separate directed checks cover the reset state, a request made while busy, and a request made in the cycle of `done`.

// File: rtl/ea_pkg.sv
// Shared types for the effective address generator.
// Assumes a 3-bit mode code; the code values are part of the port contract.
package ea_pkg;
    typedef enum logic [2:0] {
        M_PAGE0   = 3'd0,
        M_PAGE0_X = 3'd1,
        M_PAGE0_Y = 3'd2,
        M_FULL_X  = 3'd3,
        M_FULL_Y  = 3'd4,
        M_PRE_X   = 3'd5,
        M_POST_Y  = 3'd6,
        M_INVALID = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RD_LO,
        S_RD_HI,
        S_FINISH
    } ea_state_e;
endpackage

// File: rtl/ea_index_add.sv
// Combinational index arithmetic for the direct modes, plus the first-page
// pointer base for the indirect modes.
// Assumes the first page is the lowest 2**DW addresses; sums in it wrap.
module ea_index_add
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [2:0]    mode,
    input  logic [AW-1:0] operand,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    output logic [AW-1:0] direct_ea,
    output logic          direct_pc,
    output logic [DW-1:0] ptr_base,
    output logic          is_ind,
    output logic          is_post,
    output logic          is_bad
);
    localparam int HW = AW - DW;

    logic [DW-1:0] idx;
    logic [DW-1:0] page_sum;
    logic [AW-1:0] full_sum;

    // Pick the index register and form both sum widths.
    always_comb begin
        idx      = (mode == M_PAGE0_Y || mode == M_FULL_Y) ? idx_y : idx_x;
        page_sum = operand[DW-1:0] + idx;
        full_sum = operand + {{HW{1'b0}}, idx};
    end

    // Select the direct result and classify the mode.
    always_comb begin
        direct_ea = '0;
        direct_pc = 1'b0;
        case (mode)
            M_PAGE0:             direct_ea = {{HW{1'b0}}, operand[DW-1:0]};
            M_PAGE0_X, M_PAGE0_Y: direct_ea = {{HW{1'b0}}, page_sum};
            M_FULL_X, M_FULL_Y: begin
                direct_ea = full_sum;
                direct_pc = (full_sum[AW-1:DW] != operand[AW-1:DW]);
            end
            default:             direct_ea = '0;
        endcase
        ptr_base = (mode == M_PRE_X) ? page_sum : operand[DW-1:0];
        is_ind   = (mode == M_PRE_X) || (mode == M_POST_Y);
        is_post  = (mode == M_POST_Y);
        is_bad   = (mode == M_INVALID);
    end
endmodule

// File: rtl/ea_ptr_seq.sv
// Pointer fetch sequencer for the indirect modes: two reads from the first
// page (low byte, then next byte with wrap), then the optional Y addition.
// Assumes read data is valid the cycle after the read strobe.
module ea_ptr_seq
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          post_in,
    input  logic [DW-1:0] base_in,
    input  logic [DW-1:0] idx_y,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          busy,
    output logic          fin,
    output logic [AW-1:0] fin_ea,
    output logic          fin_pc
);
    localparam int HW = AW - DW;

    ea_state_e     st;
    logic [DW-1:0] ptr;
    logic [DW-1:0] lo_byte;
    logic [DW-1:0] y_hold;
    logic          post;
    logic [AW-1:0] pointer;

    // State walk and capture of the request and the pointer low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            ptr     <= '0;
            lo_byte <= '0;
            y_hold  <= '0;
            post    <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st     <= S_RD_LO;
                    ptr    <= base_in;
                    y_hold <= idx_y;
                    post   <= post_in;
                end
                S_RD_LO: st <= S_RD_HI;
                S_RD_HI: begin
                    st      <= S_FINISH;
                    lo_byte <= mem_rdata;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // Read port drive and final address formation.
    always_comb begin
        mem_rd   = (st == S_RD_LO) || (st == S_RD_HI);
        mem_addr = {{HW{1'b0}}, (st == S_RD_HI) ? DW'(ptr + 1'b1) : ptr};
        busy     = (st != S_IDLE);
        fin      = (st == S_FINISH);
        pointer  = {mem_rdata, lo_byte};
        fin_ea   = post ? pointer + {{HW{1'b0}}, y_hold} : pointer;
        fin_pc   = post && (fin_ea[AW-1:DW] != mem_rdata);
    end

    p_hi_follows_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RD_LO) |=> (mem_rd && mem_addr[DW-1:0] == DW'($past(mem_addr[DW-1:0]) + 1'b1)));
    p_start_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start) |=> (mem_rd && mem_addr[DW-1:0] == $past(base_in)));
endmodule

// File: rtl/ea_gen.sv
// Effective address generator top. Direct modes finish one edge after the
// request; indirect modes hand off to the pointer sequencer.
// Assumes the requester holds off while busy; requests then are dropped.
module ea_gen
    import ea_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] operand,
    input  logic [DW-1:0] idx_x,
    input  logic [DW-1:0] idx_y,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic          page_cross,
    output logic          err
);
    logic [AW-1:0] direct_ea;
    logic          direct_pc;
    logic [DW-1:0] ptr_base;
    logic          is_ind;
    logic          is_post;
    logic          is_bad;
    logic          accept;
    logic          fin;
    logic [AW-1:0] fin_ea;
    logic          fin_pc;

    ea_index_add #(.AW(AW), .DW(DW)) u_add (
        .mode(mode), .operand(operand), .idx_x(idx_x), .idx_y(idx_y),
        .direct_ea(direct_ea), .direct_pc(direct_pc), .ptr_base(ptr_base),
        .is_ind(is_ind), .is_post(is_post), .is_bad(is_bad)
    );

    assign accept = req && !busy;

    ea_ptr_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(accept && is_ind), .post_in(is_post),
        .base_in(ptr_base), .idx_y(idx_y), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .busy(busy),
        .fin(fin), .fin_ea(fin_ea), .fin_pc(fin_pc)
    );

    // Result registers: load on a direct accept or at the end of a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            ea         <= '0;
            page_cross <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept && !is_ind) begin
                done       <= 1'b1;
                ea         <= is_bad ? '0 : direct_ea;
                page_cross <= direct_pc;
                err        <= is_bad;
            end else if (fin) begin
                done       <= 1'b1;
                ea         <= fin_ea;
                page_cross <= fin_pc;
                err        <= 1'b0;
            end
        end
    end

    p_no_done_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ea) && $stable(err) && $stable(page_cross)));
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (ea == '0 && !page_cross));
    p_rd_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);
    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req && !fin) |=> busy);
endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] operand = 16'h0;
    logic [7:0]  idx_x = 8'h0;
    logic [7:0]  idx_y = 8'h0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h0;
    logic        busy, done, page_cross, err;
    logic [15:0] ea;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] zmem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen i_ea_gen (
        .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .operand(operand),
        .idx_x(idx_x), .idx_y(idx_y), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea),
        .page_cross(page_cross), .err(err)
    );

    // Pointer memory: one-cycle read latency.
    always @(posedge clk) if (mem_rd) mem_rdata <= zmem[mem_addr[7:0]];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    int          m_cnt = 0;
    logic        m_done = 0, m_pc = 0, m_err = 0;
    logic [15:0] m_ea = 0, p_ea = 0;
    logic        p_pc = 0;
    logic [7:0]  m_p = 0;
    string       m_tag = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 0; m_ea = 0; m_pc = 0; m_err = 0; m_tag = "R1";
        end else begin
            m_done = 0;
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_done = 1; m_ea = p_ea; m_pc = p_pc; m_err = 0;
                end
            end else if (req) begin
                logic [7:0]  lo, hi;
                logic [16:0] s;
                case (mode)
                    3'd0: begin m_ea = {8'h00, operand[7:0]}; m_pc = 0; m_tag = "R2"; end
                    3'd1: begin m_ea = (operand[7:0] + idx_x) % 256; m_pc = 0; m_tag = "R3"; end
                    3'd2: begin m_ea = (operand[7:0] + idx_y) % 256; m_pc = 0; m_tag = "R3"; end
                    3'd3, 3'd4: begin
                        s = operand + ((mode == 3'd3) ? idx_x : idx_y);
                        m_ea = s[15:0]; m_pc = (s[15:8] != operand[15:8]); m_tag = "R4";
                    end
                    3'd5: begin
                        m_p = operand[7:0] + idx_x;
                        lo = zmem[m_p]; hi = zmem[8'(m_p + 1)];
                        p_ea = {hi, lo}; p_pc = 0; m_cnt = 3; m_tag = "R5";
                    end
                    3'd6: begin
                        m_p = operand[7:0];
                        lo = zmem[m_p]; hi = zmem[8'(m_p + 1)];
                        s = {hi, lo} + idx_y;
                        p_ea = s[15:0]; p_pc = (s[15:8] != hi); m_cnt = 3; m_tag = "R6";
                    end
                    default: begin m_ea = 0; m_pc = 0; m_tag = "R9"; end
                endcase
                if (m_cnt == 0) begin m_done = 1; m_err = (mode == 3'd7); end
            end
        end
    end

    // Compare every output on the falling edge.
    always @(negedge clk) if (!finished) begin
        chk({m_tag, " done"}, done, m_done);
        chk("R10 busy", busy, m_cnt != 0);
        chk({m_tag, " ea"}, ea, m_ea);
        chk({m_tag, " page_cross"}, page_cross, m_pc);
        chk({m_tag, " err"}, err, m_err);
        chk("R7 mem_rd", mem_rd, (m_cnt == 3 || m_cnt == 2));
        if (m_cnt == 3) chk("R7 low address", mem_addr, {8'h00, m_p});
        if (m_cnt == 2) chk("R7 high address", mem_addr, {8'h00, 8'(m_p + 1)});
    end

    task automatic issue(logic [2:0] md, logic [15:0] op, logic [7:0] x, logic [7:0] y);
        @(negedge clk);
        req = 1; mode = md; operand = op; idx_x = x; idx_y = y;
        @(negedge clk);
        req = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) zmem[i] = 8'((i * 29 + 7) & 255);
        zmem[8'hFF] = 8'hF0;
        zmem[8'h00] = 8'h12;
        repeat (3) @(negedge clk);
        chk("R1 reset done", done, 0);
        chk("R1 reset ea", ea, 0);
        chk("R1 reset mem_rd", mem_rd, 0);
        rst_n = 1;
        issue(3'd0, 16'hAB34, 8'h11, 8'h22);          // R2
        issue(3'd1, 16'h0001, 8'hFF, 8'h00);          // R3 wrap to 0
        issue(3'd1, 16'h0080, 8'h10, 8'h00);          // R3
        issue(3'd2, 16'h00F0, 8'h00, 8'h20);          // R3 Y wrap
        issue(3'd3, 16'hF453, 8'h03, 8'h00);          // R4 no cross
        issue(3'd3, 16'h12F0, 8'h20, 8'h00);          // R4 cross
        issue(3'd4, 16'hFFFF, 8'h00, 8'h01);          // R4 16-bit wrap
        issue(3'd5, 16'h0020, 8'h04, 8'h00);          // R5
        issue(3'd5, 16'h00FE, 8'h01, 8'h00);          // R5 high byte from 0
        issue(3'd6, 16'h0040, 8'h00, 8'h05);          // R6
        issue(3'd6, 16'h00FF, 8'h00, 8'hFF);          // R6 wrap and cross
        issue(3'd7, 16'h1234, 8'h01, 8'h02);          // R9
        chk("R9 err after unsupported", err, 1);
        // R8: request while busy is dropped.
        @(negedge clk);
        req = 1; mode = 3'd6; operand = 16'h0040; idx_y = 8'h05;
        @(negedge clk);
        mode = 3'd0; operand = 16'h0077;
        @(negedge clk);
        req = 0;
        repeat (4) @(negedge clk);
        chk("R8 busy request dropped", ea, {zmem[8'h41], zmem[8'h40]} + 16'h5);
        // R8/R10: request held into the done cycle is accepted there.
        @(negedge clk);
        req = 1; mode = 3'd0; operand = 16'h0055;
        @(negedge clk);
        chk("R10 first done", done, 1);
        @(negedge clk);
        req = 0;
        chk("R8 accepted in done cycle", done, 1);
        @(negedge clk);
        chk("R10 single pulse", done, 0);
        chk("R10 ea held", ea, 16'h0055);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule